// File: doc/BRIEF.md
# GPIO interrupt status aggregator

This block gathers interrupt requests from six general-purpose input lines. Each line first passes through a two-flop synchronizer. It must then stay high for a set number of system clock cycles, which filters out pulses too short to count. A line that qualifies sets a sticky status bit. The status bit is recorded whether or not its source is enabled. Software reads status and enable through one 32-bit register and clears a status bit by writing a one to it.

The status bits that software has enabled are ORed into one summary event. That event reaches the registered interrupt pin only when a separate global enable input is also high. A system interrupt controller, kept outside this block, supplies that global enable and watches the summary event alongside its other sources.

Top module: `gpio_irq_agg`

## Requirements
- R1: The register reads the six enable bits at positions 21:16 and the six status bits at positions 5:0; all other bit positions read as zero and ignore writes.
- R2: After reset the status bits, the enable bits, `evt_o` and `irq_o` are all zero.
- R3: A line held high sets its status bit on the QUAL_CYCLES+3rd rising edge after it goes high (two edges of synchronizer, QUAL_CYCLES edges of qualification, one edge to latch); with QUAL_CYCLES=3 that is the 6th edge.
- R4: A line that is high for fewer than QUAL_CYCLES clock cycles leaves its status bit at zero.
- R5: A status bit sets when its line qualifies, even while its enable bit is zero.
- R6: A register write with a one in status bit k clears that bit on the write's clock edge; a zero in bit k leaves it unchanged.
- R7: When a qualified line and a write-one clear meet the same status bit in the same cycle, the bit stays set, so a line still held high cannot be cleared.
- R8: A register write loads bits 21:16 into the enable bits, which then read back unchanged.
- R9: `evt_o` is high exactly when some status bit and its enable bit are both one, with no clock delay.
- R10: `irq_o` equals, one clock later, the AND of `evt_o` and `glb_en_i`.
- R11: A status bit that is one goes to zero only on a cycle where a write carried a one in that bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read value |
| gpio_i | input | 6 | Asynchronous, level-sensitive interrupt request lines |
| glb_en_i | input | 1 | Global enable for the GPIO interrupt |
| evt_o | output | 1 | Summary event: OR of the enabled status bits |
| irq_o | output | 1 | Registered interrupt output |

## Verification
On every cycle the assertions check four things: reserved bits read zero, status bits stay sticky unless a write clears them, enable writes read back, and the interrupt output follows the gated event one cycle later. Some behaviour depends on the input lines over a span of time, and only the bench scenarios can show it. That covers the exact edge on which a held line sets its status bit, the rejection of a pulse one cycle too short, the set-over-clear rule while a line is held, and status latching while the source is disabled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned REG_W = 32;

   // width of a saturating counter that must hold the value lim
   function automatic int unsigned cnt_width(input int unsigned lim);
      int unsigned w;
      w = 1;
      while ((1 << w) <= lim) w++;
      return w;
   endfunction

   // bit mask of n ones placed at position lsb
   function automatic logic [REG_W-1:0] field_mask(input int unsigned n, input int unsigned lsb);
      logic [REG_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < n; i++) m[lsb+i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);
   initial begin
      if (STAGES < 2) $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
      end else begin
         pipe[0] <= async_i;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/gpio_qual.sv
module gpio_qual #(
   parameter int unsigned QUAL_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic qual_o
);
   import gpio_irq_pkg::*;

   generate
      if (QUAL_CYCLES <= 1) begin : g_pass
         // a single sampled high level already meets the minimum width
         assign qual_o = lvl_i;
      end else begin : g_count
         localparam int unsigned CW = cnt_width(QUAL_CYCLES);
         localparam logic [CW-1:0] LIM = CW'(QUAL_CYCLES);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          run_q <= '0;
            else if (!lvl_i)     run_q <= '0;
            else if (run_q != LIM) run_q <= run_q + 1'b1;
         end

         assign qual_o = (run_q == LIM);
      end
   endgenerate
endmodule

// File: rtl/gpio_sts_bank.sv
module gpio_sts_bank #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         wr_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] en_d_i,
   output logic [N-1:0] sts_o,
   output logic [N-1:0] en_o
);
   logic [N-1:0] sts_q, en_q;

   genvar k;
   generate
      for (k = 0; k < N; k++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 sts_q[k] <= 1'b0;
            else if (set_i[k])          sts_q[k] <= 1'b1;   // set beats clear
            else if (wr_i && clr_i[k])  sts_q[k] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_q <= '0;
      else if (wr_i) en_q <= en_d_i;
   end

   assign sts_o = sts_q;
   assign en_o  = en_q;
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
   parameter int unsigned NUM_SRC     = 6,
   parameter int unsigned STS_LSB     = 0,
   parameter int unsigned EN_LSB      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned QUAL_CYCLES = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_i,
   input  logic [31:0] reg_wdata_i,
   output logic [31:0] reg_rdata_o,
   input  logic [5:0]  gpio_i,
   input  logic        glb_en_i,
   output logic        evt_o,
   output logic        irq_o
);
   import gpio_irq_pkg::*;

   generate
      if (NUM_SRC != 6) begin : g_bad_n
         $error("gpio_irq_agg: port width fixes NUM_SRC at 6");
      end
      if (STS_LSB + NUM_SRC > EN_LSB) begin : g_bad_overlap
         $error("gpio_irq_agg: status and enable fields overlap");
      end
      if (EN_LSB + NUM_SRC > REG_W) begin : g_bad_range
         $error("gpio_irq_agg: enable field exceeds register width");
      end
   endgenerate

   logic [NUM_SRC-1:0] lvl_sync, lvl_qual, sts, en;

   gpio_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .async_i(gpio_i), .sync_o(lvl_sync)
   );

   genvar k;
   generate
      for (k = 0; k < NUM_SRC; k++) begin : g_qual
         gpio_qual #(.QUAL_CYCLES(QUAL_CYCLES)) i_qual (
            .clk(clk), .rst_n(rst_n), .lvl_i(lvl_sync[k]), .qual_o(lvl_qual[k])
         );
      end
   endgenerate

   gpio_sts_bank #(.N(NUM_SRC)) i_bank (
      .clk(clk), .rst_n(rst_n),
      .set_i(lvl_qual),
      .wr_i(reg_wr_i),
      .clr_i(reg_wdata_i[STS_LSB +: NUM_SRC]),
      .en_d_i(reg_wdata_i[EN_LSB +: NUM_SRC]),
      .sts_o(sts), .en_o(en)
   );

   always_comb begin
      reg_rdata_o = '0;
      reg_rdata_o[STS_LSB +: NUM_SRC] = sts;
      reg_rdata_o[EN_LSB  +: NUM_SRC] = en;
   end

   assign evt_o = |(sts & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= evt_o & glb_en_i;
   end
endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
   parameter int unsigned NUM_SRC = 6,
   parameter int unsigned STS_LSB = 0,
   parameter int unsigned EN_LSB  = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr_i,
   input logic [31:0] reg_wdata_i,
   input logic [31:0] reg_rdata_o,
   input logic        glb_en_i,
   input logic        evt_o,
   input logic        irq_o
);
   import gpio_irq_pkg::*;
   localparam logic [31:0] USED = field_mask(NUM_SRC, STS_LSB) | field_mask(NUM_SRC, EN_LSB);

   // R1: reserved positions never read as one
   assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata_o & ~USED) == 32'h0);

   // R11: a status bit falls only where the previous cycle wrote a one
   assert_sts_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reg_rdata_o[STS_LSB +: NUM_SRC]) & ~reg_rdata_o[STS_LSB +: NUM_SRC]
       & ~($past(reg_wr_i) ? $past(reg_wdata_i[STS_LSB +: NUM_SRC]) : {NUM_SRC{1'b0}}))
      == {NUM_SRC{1'b0}});

   // R8: written enable field reads back after the edge
   assert_en_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_i |=> reg_rdata_o[EN_LSB +: NUM_SRC] == $past(reg_wdata_i[EN_LSB +: NUM_SRC]));

   // R10: interrupt output is the gated event delayed one cycle
   assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == $past(evt_o && glb_en_i));

   // R10: the pin never rises without the global enable the cycle before
   assert_irq_needs_glb_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(glb_en_i));
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.NUM_SRC(NUM_SRC), .STS_LSB(STS_LSB), .EN_LSB(EN_LSB)) i_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
   .reg_rdata_o(reg_rdata_o), .glb_en_i(glb_en_i), .evt_o(evt_o), .irq_o(irq_o)
);

// File: tb/test_gpio_irq_agg.sv
module test_gpio_irq_agg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_i = 1'b0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic [5:0]  gpio_i = '0;
   logic        glb_en_i = 1'b0;
   logic        evt_o, irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   gpio_irq_agg i_gpio_irq_agg (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .gpio_i(gpio_i), .glb_en_i(glb_en_i),
      .evt_o(evt_o), .irq_o(irq_o)
   );

   // {line mask, enable, global, expected status, expected evt, expected irq}
   localparam logic [20:0] VEC [6] = '{
      {6'h01, 6'h01, 1'b1, 6'h01, 1'b1, 1'b1},
      {6'h04, 6'h02, 1'b1, 6'h04, 1'b0, 1'b0},
      {6'h3F, 6'h3F, 1'b0, 6'h3F, 1'b1, 1'b0},
      {6'h20, 6'h20, 1'b1, 6'h20, 1'b1, 1'b1},
      {6'h0A, 6'h08, 1'b1, 6'h0A, 1'b1, 1'b1},
      {6'h00, 6'h3F, 1'b1, 6'h00, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      reg_wr_i = 1'b1;
      reg_wdata_i = d;
      @(negedge clk);
      reg_wr_i = 1'b0;
      reg_wdata_i = '0;
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      cyc(3);
      // R2: reset state
      chk("R2 rdata", reg_rdata_o, 32'h0);
      chk("R2 evt", {31'b0, evt_o}, 32'h0);
      chk("R2 irq", {31'b0, irq_o}, 32'h0);
      rst_n = 1'b1;
      cyc(2);

      // table walk: R5, R9, R10 over several patterns
      foreach (VEC[v]) begin
         wr(32'h0000_003F);
         wr({10'b0, VEC[v][14:9], 16'h0});
         glb_en_i = VEC[v][8];
         gpio_i = VEC[v][20:15];
         cyc(8);
         gpio_i = '0;
         cyc(6);
         chk($sformatf("R5 status row %0d", v), reg_rdata_o,
             {10'b0, VEC[v][14:9], 10'b0, VEC[v][7:2]});
         chk($sformatf("R9 evt row %0d", v), {31'b0, evt_o}, {31'b0, VEC[v][1]});
         chk($sformatf("R10 irq row %0d", v), {31'b0, irq_o}, {31'b0, VEC[v][0]});
      end

      // R1: reserved bits ignore writes and read zero
      wr(32'h0000_003F);
      wr(32'hFFFF_FFC0);
      chk("R1 reserved", reg_rdata_o, 32'h003F_0000);
      // R8: enable field read/write
      wr(32'h0015_0000);
      chk("R8 enable", reg_rdata_o, 32'h0015_0000);
      wr(32'h0000_0000);
      glb_en_i = 1'b0;

      // R3: exact latch edge with QUAL_CYCLES=3
      gpio_i[0] = 1'b1;
      cyc(5);
      chk("R3 before edge 6", reg_rdata_o & 32'h3F, 32'h0);
      cyc(1);
      chk("R3 at edge 6", reg_rdata_o & 32'h3F, 32'h1);
      gpio_i[0] = 1'b0;
      cyc(6);

      // R6: write zero leaves it, write one clears
      wr(32'h0000_0000);
      chk("R6 zero write", reg_rdata_o & 32'h3F, 32'h1);
      wr(32'h0000_0001);
      chk("R6 one write", reg_rdata_o & 32'h3F, 32'h0);

      // R4: pulse of two cycles is rejected
      gpio_i[2] = 1'b1;
      cyc(2);
      gpio_i[2] = 1'b0;
      cyc(10);
      chk("R4 short pulse", reg_rdata_o & 32'h3F, 32'h0);
      // three-cycle pulse is accepted
      gpio_i[2] = 1'b1;
      cyc(3);
      gpio_i[2] = 1'b0;
      cyc(10);
      chk("R3 minimum pulse", reg_rdata_o & 32'h3F, 32'h4);
      wr(32'h0000_0004);

      // R7: clear while line held high loses to the set
      gpio_i[1] = 1'b1;
      cyc(8);
      wr(32'h0000_0002);
      chk("R7 held clear", reg_rdata_o & 32'h3F, 32'h2);
      gpio_i[1] = 1'b0;
      cyc(6);
      wr(32'h0000_0002);
      chk("R7 clear after release", reg_rdata_o & 32'h3F, 32'h0);

      // R10: global enable gates with one cycle of delay
      gpio_i[3] = 1'b1;
      cyc(8);
      gpio_i[3] = 1'b0;
      wr(32'h0008_0000);
      chk("R9 evt enabled", {31'b0, evt_o}, 32'h1);
      chk("R10 irq gated off", {31'b0, irq_o}, 32'h0);
      glb_en_i = 1'b1;
      #1;
      chk("R10 irq no early rise", {31'b0, irq_o}, 32'h0);
      cyc(1);
      chk("R10 irq rises", {31'b0, irq_o}, 32'h1);
      glb_en_i = 1'b0;
      cyc(1);
      chk("R10 irq falls", {31'b0, irq_o}, 32'h0);

      done = 1;
      report();
   end
endmodule